// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer with DRAM Refresh

This block turns a request for one machine cycle into the T-state sequence of an 8-bit processor's external bus. It drives the active-low strobes, the 16-bit address, the write data and its output enable. Each T-state is one clock. A request is taken only while the sequencer is idle.

Opcode fetches and interrupt acknowledges end with a two-T-state refresh phase. In that phase the address carries the interrupt-page register in the upper byte and the refresh register in the lower byte. The refresh register counts opcode-type cycles in its low seven bits, and its top bit is left untouched by the count. The sequencer adds wait states in two ways: a fixed number that depends on the cycle type, and one more for each low sample of the wait input. Between cycles it can hand the bus to an external master, floating the address, data and control lines while the grant is held.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst` is high, all six strobes and `busack_n` are high, `addr_oe`, `ctrl_oe` and `data_oe` are low, and after a reset edge `pc_value`, `r_value` and the interrupt-page register are zero.
- R2: `req_kind` codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge. An opcode fetch holds `m1_n`, `mreq_n` and `rd_n` low with `addr` = `pc_value` until the refresh phase. With no waits it lasts 4 T-states, and `rdata` then holds `data_in` as sampled at the end of the last T2/wait state.
- R3: In the last two T-states of an opcode fetch or interrupt acknowledge, `rfsh_n` and `mreq_n` are low, `rd_n` and `m1_n` are high, and `addr` = {interrupt-page register, refresh register}.
- R4: Each opcode fetch and interrupt acknowledge increments bits 6..0 of the refresh register modulo 128 at the cycle's end while bit 7 is kept; `r_value` shows the incremented value once the cycle is over.
- R5: A pulse on `r_load` loads all 8 bits of the refresh register from `r_val`, including bit 7.
- R6: The wait input is sampled at the end of T2 and of each wait state once the automatic waits are used up; each low sample adds one T-state.
- R7: I/O read and write cycles hold `iorq_n` low with `mreq_n` high, take one automatic wait state, and last 4 T-states with no external waits.
- R8: An interrupt acknowledge holds `m1_n` low from T1 and `iorq_n` low from T2 until the refresh phase, takes two automatic wait states, lasts 6 T-states with no external waits, and leaves `pc_value` unchanged.
- R9: Memory read and write cycles hold `mreq_n` low and last 3 T-states with no waits; `rd_n` and `wr_n` are never low together; `wr_n` goes low from T2 on.
- R10: In write cycles `data_oe` is high and `data_out` equals the request's write data from T1 through the last T-state; `data_oe` is low once the cycle has ended.
- R11: A low `busreq_n` is acted on only between machine cycles. It then sets `busack_n` low and `addr_oe`, `ctrl_oe` and `data_oe` low until it is released, and no requested cycle is started meanwhile.
- R12: `pc_value` increments by one at the end of each opcode fetch and holds in every other cycle type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Machine-cycle request, taken when `ready` |
| req_kind | input | 3 | Cycle type code |
| req_addr | input | 16 | Address for memory and I/O cycles |
| req_wdata | input | 8 | Write data for write cycles |
| ready | output | 1 | Idle and not granting the bus |
| done | output | 1 | High during the last T-state of a cycle |
| wait_n | input | 1 | Active-low wait request |
| busreq_n | input | 1 | Active-low bus request |
| busack_n | output | 1 | Active-low bus grant |
| i_load | input | 1 | Load the interrupt-page register |
| i_val | input | 8 | Interrupt-page load value |
| r_load | input | 1 | Load the refresh register |
| r_val | input | 8 | Refresh register load value |
| r_value | output | 8 | Current refresh register |
| pc_value | output | 16 | Current program counter |
| data_in | input | 8 | Data bus input |
| data_out | output | 8 | Data bus output value |
| data_oe | output | 1 | Data bus output enable |
| rdata | output | 8 | Data captured in the last read-type cycle |
| addr | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus output enable |
| ctrl_oe | output | 1 | Strobe output enable |
| m1_n | output | 1 | Opcode-type cycle marker |
| mreq_n | output | 1 | Memory request |
| iorq_n | output | 1 | I/O request |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| rfsh_n | output | 1 | Refresh phase marker |

## Verification
The in-line assertions check on every cycle that read and write never overlap, that refresh always comes with a memory request and no read, that the bus is floated whenever the grant is given, that the refresh counter's top bit moves only on a load, and that the program counter holds outside fetches. Only the bench's scenarios can show the cycle lengths that come from automatic and external waits, the strobe pattern at each T-state of all six cycle types, the refresh address contents, the modulo-128 wrap with bit 7 kept, and that a bus request made mid-cycle waits for the cycle to finish.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        CYC_FETCH = 3'd0,
        CYC_MRD   = 3'd1,
        CYC_MWR   = 3'd2,
        CYC_IORD  = 3'd3,
        CYC_IOWR  = 3'd4,
        CYC_INTA  = 3'd5
    } cyc_kind_e;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_T1,
        TS_T2,
        TS_TW,
        TS_T3,
        TS_T4,
        TS_BACK
    } tstate_e;

    typedef struct packed {
        logic m1_n;
        logic mreq_n;
        logic iorq_n;
        logic rd_n;
        logic wr_n;
        logic rfsh_n;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '{default: 1'b1};

    function automatic logic [1:0] auto_waits(cyc_kind_e k);
        case (k)
            CYC_IORD, CYC_IOWR: return 2'd1;
            CYC_INTA:           return 2'd2;
            default:            return 2'd0;
        endcase
    endfunction

    function automatic logic has_refresh(cyc_kind_e k);
        return (k == CYC_FETCH) || (k == CYC_INTA);
    endfunction

    function automatic logic is_write(cyc_kind_e k);
        return (k == CYC_MWR) || (k == CYC_IOWR);
    endfunction

    function automatic logic kind_ok(logic [2:0] code);
        return code <= 3'd5;
    endfunction

endpackage

// File: rtl/tstate_fsm.sv
module tstate_fsm
    import busseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       busreq_n,
    input  logic       wait_n,
    output tstate_e    state,
    output cyc_kind_e  kind_q,
    output logic       accept,
    output logic       sample_now,
    output logic       cyc_end
);

    logic [1:0] wcnt;

    assign accept     = (state == TS_IDLE) && busreq_n && req_valid && kind_ok(req_kind);
    assign sample_now = ((state == TS_T2) || (state == TS_TW)) && (wcnt == 2'd0) && wait_n;
    assign cyc_end    = (state == TS_T4) || ((state == TS_T3) && !has_refresh(kind_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TS_IDLE;
            kind_q <= CYC_FETCH;
            wcnt   <= 2'd0;
        end else begin
            case (state)
                TS_IDLE: begin
                    if (!busreq_n) begin
                        state <= TS_BACK;
                    end else if (accept) begin
                        state  <= TS_T1;
                        kind_q <= cyc_kind_e'(req_kind);
                    end
                end
                TS_BACK: if (busreq_n) state <= TS_IDLE;
                TS_T1: begin
                    state <= TS_T2;
                    wcnt  <= auto_waits(kind_q);
                end
                TS_T2, TS_TW: begin
                    if (wcnt != 2'd0) begin
                        state <= TS_TW;
                        wcnt  <= wcnt - 2'd1;
                    end else if (!wait_n) begin
                        state <= TS_TW;
                    end else begin
                        state <= TS_T3;
                    end
                end
                TS_T3: state <= has_refresh(kind_q) ? TS_T4 : TS_IDLE;
                TS_T4: state <= TS_IDLE;
                default: state <= TS_IDLE;
            endcase
        end
    end

    // R11: a granted bus stays granted while the request is held
    a_r11_grant_hold: assert property (@(posedge clk) disable iff (rst)
        (state == TS_BACK && !busreq_n) |=> (state == TS_BACK));

    // R11: a grant is never entered from inside a machine cycle
    a_r11_grant_between: assert property (@(posedge clk) disable iff (rst)
        (state != TS_IDLE && state != TS_BACK) |=> (state != TS_BACK));

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import busseq_pkg::*;
(
    input  tstate_e   state,
    input  cyc_kind_e kind_q,
    output strobes_t  strb,
    output logic      refresh_phase,
    output logic      data_drive
);

    logic early;
    logic mid;
    logic body;

    always_comb begin
        early         = (state == TS_T1) || (state == TS_T2) || (state == TS_TW);
        mid           = (state == TS_T2) || (state == TS_TW);
        body          = early || (state == TS_T3);
        refresh_phase = has_refresh(kind_q) && ((state == TS_T3) || (state == TS_T4));
        data_drive    = is_write(kind_q) && body;

        strb = STROBES_IDLE;
        case (kind_q)
            CYC_FETCH: begin
                if (early) begin
                    strb.m1_n   = 1'b0;
                    strb.mreq_n = 1'b0;
                    strb.rd_n   = 1'b0;
                end
            end
            CYC_INTA: begin
                if (early) strb.m1_n   = 1'b0;
                if (mid)   strb.iorq_n = 1'b0;
            end
            CYC_MRD: begin
                if (body) begin
                    strb.mreq_n = 1'b0;
                    strb.rd_n   = 1'b0;
                end
            end
            CYC_MWR: begin
                if (body) strb.mreq_n = 1'b0;
                if (body && state != TS_T1) strb.wr_n = 1'b0;
            end
            CYC_IORD: begin
                if (body) begin
                    strb.iorq_n = 1'b0;
                    strb.rd_n   = 1'b0;
                end
            end
            CYC_IOWR: begin
                if (body) strb.iorq_n = 1'b0;
                if (body && state != TS_T1) strb.wr_n = 1'b0;
            end
            default: strb = STROBES_IDLE;
        endcase

        if (refresh_phase) begin
            strb.mreq_n = 1'b0;
            strb.rfsh_n = 1'b0;
        end
    end

endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] r_q
);

    localparam int CNT_W = DATA_W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else if (load) begin
            r_q <= load_val;
        end else if (inc) begin
            r_q <= {r_q[DATA_W-1], r_q[CNT_W-1:0] + {{(CNT_W-1){1'b0}}, 1'b1}};
        end
    end

    // R4: the top bit moves only through a load
    a_r4_top_bit_kept: assert property (@(posedge clk) disable iff (rst)
        !load |=> (r_q[DATA_W-1] == $past(r_q[DATA_W-1])));

    // R4: without load or increment the whole register holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !inc) |=> $stable(r_q));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import busseq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          done,
    input  logic          wait_n,
    input  logic          busreq_n,
    output logic          busack_n,
    input  logic          i_load,
    input  logic [DW-1:0] i_val,
    input  logic          r_load,
    input  logic [DW-1:0] r_val,
    output logic [DW-1:0] r_value,
    output logic [AW-1:0] pc_value,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic          addr_oe,
    output logic          ctrl_oe,
    output logic          m1_n,
    output logic          mreq_n,
    output logic          iorq_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          rfsh_n
);

    localparam int HI_W = AW - DW;

    tstate_e       state;
    cyc_kind_e     kind_q;
    logic          accept;
    logic          sample_now;
    logic          cyc_end;
    strobes_t      strb;
    logic          refresh_phase;
    logic          data_drive;
    logic [DW-1:0] r_q;
    logic [HI_W-1:0] ireg;
    logic [AW-1:0] pc;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    tstate_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .busreq_n   (busreq_n),
        .wait_n     (wait_n),
        .state      (state),
        .kind_q     (kind_q),
        .accept     (accept),
        .sample_now (sample_now),
        .cyc_end    (cyc_end)
    );

    strobe_decode u_dec (
        .state         (state),
        .kind_q        (kind_q),
        .strb          (strb),
        .refresh_phase (refresh_phase),
        .data_drive    (data_drive)
    );

    refresh_ctr #(.DATA_W(DW)) u_rfsh (
        .clk      (clk),
        .rst      (rst),
        .inc      (cyc_end && has_refresh(kind_q)),
        .load     (r_load),
        .load_val (r_val),
        .r_q      (r_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            ireg    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (i_load) ireg <= i_val[HI_W-1:0];
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (sample_now && !is_write(kind_q)) rdata_q <= data_in;
            if (cyc_end && kind_q == CYC_FETCH) pc <= pc + {{(AW-1){1'b0}}, 1'b1};
        end
    end

    always_comb begin
        if (refresh_phase)          addr = {ireg, r_q};
        else if (has_refresh(kind_q)) addr = pc;
        else                        addr = addr_q;
    end

    assign addr_oe  = !rst && (state != TS_BACK);
    assign ctrl_oe  = !rst && (state != TS_BACK);
    assign data_oe  = !rst && data_drive;
    assign data_out = wdata_q;
    assign busack_n = rst || (state != TS_BACK);
    assign ready    = !rst && (state == TS_IDLE) && busreq_n;
    assign done     = !rst && cyc_end;
    assign rdata    = rdata_q;
    assign r_value  = r_q;
    assign pc_value = pc;

    assign m1_n   = rst | strb.m1_n;
    assign mreq_n = rst | strb.mreq_n;
    assign iorq_n = rst | strb.iorq_n;
    assign rd_n   = rst | strb.rd_n;
    assign wr_n   = rst | strb.wr_n;
    assign rfsh_n = rst | strb.rfsh_n;

    // R9: read and write strobes never overlap
    a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R3: refresh comes with a memory request and no read
    a_r3_rfsh_mreq: assert property (@(posedge clk) disable iff (rst)
        !rfsh_n |-> (!mreq_n && rd_n && m1_n));

    // R11: a granted bus is fully floated
    a_r11_float: assert property (@(posedge clk) disable iff (rst)
        !busack_n |-> (!addr_oe && !ctrl_oe && !data_oe));

    // R12: the program counter moves only at the end of a fetch
    a_r12_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !(done && kind_q == CYC_FETCH) |=> $stable(pc_value));

    // R8: acknowledge never asserts a memory request outside refresh
    a_r8_inta_no_mreq: assert property (@(posedge clk) disable iff (rst)
        (!m1_n && !iorq_n) |-> mreq_n);

endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, done;
    logic        wait_n = 1'b1;
    logic        busreq_n = 1'b1;
    logic        busack_n;
    logic        i_load = 1'b0;
    logic [7:0]  i_val = '0;
    logic        r_load = 1'b0;
    logic [7:0]  r_val = '0;
    logic [7:0]  r_value;
    logic [15:0] pc_value;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [7:0]  rdata;
    logic [15:0] addr;
    logic        addr_oe, ctrl_oe;
    logic        m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [15:0] pc_m = '0;
    logic [7:0]  r_m = '0;
    logic [7:0]  i_m = '0;
    int          busreq_at = 0;

    always #2 clk = ~clk;

    bus_cycle_seq u_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
        .wait_n(wait_n), .busreq_n(busreq_n), .busack_n(busack_n),
        .i_load(i_load), .i_val(i_val), .r_load(r_load), .r_val(r_val),
        .r_value(r_value), .pc_value(pc_value), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .rdata(rdata), .addr(addr),
        .addr_oe(addr_oe), .ctrl_oe(ctrl_oe), .m1_n(m1_n), .mreq_n(mreq_n),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // strobe vector order: m1 mreq iorq rd wr rfsh
    task automatic run_cyc(input int kind, input logic [15:0] a, input logic [7:0] wd,
                           input int nw, input logic [7:0] din);
        int aw;
        int base;
        int exp_len;
        int t3pos;
        int n;
        bit rfk;
        bit rf;
        bit pre;
        bit wr_kind;
        logic [5:0] es;
        logic [15:0] ea;
        string tag;
        aw      = (kind == 3 || kind == 4) ? 1 : (kind == 5 ? 2 : 0);
        rfk     = (kind == 0 || kind == 5);
        wr_kind = (kind == 2 || kind == 4);
        base    = rfk ? 4 : 3;
        exp_len = base + aw + nw;
        t3pos   = exp_len - (rfk ? 1 : 0);
        case (kind)
            0: tag = "R2/R3 fetch";
            1: tag = "R9 memrd";
            2: tag = "R9/R10 memwr";
            3: tag = "R7 iord";
            4: tag = "R7/R10 iowr";
            default: tag = "R8 inta";
        endcase
        chk(ready == 1'b1, "R11 ready before request", 32'(ready), 32'd1);
        req_valid = 1'b1; req_kind = 3'(kind); req_addr = a; req_wdata = wd;
        data_in = din; wait_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (1) begin
            wait_n = !((n >= 2 + aw) && (n < 2 + aw + nw));
            if (busreq_at != 0 && n == busreq_at) busreq_n = 1'b0;
            pre = (n < t3pos);
            rf  = rfk && !pre;
            es  = 6'b111111;
            case (kind)
                0: begin
                    if (pre) es = 6'b001011;
                end
                5: begin
                    if (pre) es[5] = 1'b0;
                    if (pre && n >= 2) es[3] = 1'b0;
                end
                1: es = 6'b101011;
                2: es = (n >= 2) ? 6'b101101 : 6'b101111;
                3: es = 6'b110011;
                default: es = (n >= 2) ? 6'b110101 : 6'b110111;
            endcase
            if (rf) es = 6'b101110;
            ea = rf ? {i_m, r_m} : (rfk ? pc_m : a);
            chk({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n} == es,
                {tag, " strobes (R3 in refresh, R6 waits)"},
                32'({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}), 32'(es));
            chk(addr == ea, {tag, " address"}, 32'(addr), 32'(ea));
            chk(!(rd_n == 1'b0 && wr_n == 1'b0), "R9 rd/wr exclusive", 32'({rd_n, wr_n}), 32'h3);
            if (wr_kind) begin
                chk(data_oe == 1'b1 && data_out == wd, "R10 write data driven",
                    32'({data_oe, data_out}), 32'({1'b1, wd}));
            end else begin
                chk(data_oe == 1'b0, "R10 no drive on read", 32'(data_oe), 32'd0);
            end
            if (done || n > 20) break;
            @(negedge clk);
            n++;
        end
        chk(n == exp_len, {tag, " length (R6 waits)"}, 32'(n), 32'(exp_len));
        wait_n = 1'b1;
        @(negedge clk);
        if (kind == 0) pc_m = pc_m + 16'd1;
        if (rfk) r_m = {r_m[7], r_m[6:0] + 7'd1};
        chk(r_value == r_m, "R4 refresh register after cycle", 32'(r_value), 32'(r_m));
        chk(pc_value == pc_m, "R12 program counter", 32'(pc_value), 32'(pc_m));
        if (!wr_kind) chk(rdata == din, {tag, " read data"}, 32'(rdata), 32'(din));
        else          chk(data_oe == 1'b0, "R10 released after write", 32'(data_oe), 32'd0);
    endtask

    task automatic load_r(input logic [7:0] v);
        r_load = 1'b1; r_val = v;
        @(negedge clk);
        r_load = 1'b0;
        r_m = v;
        chk(r_value == v, "R5 refresh register load", 32'(r_value), 32'(v));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, busack_n} == 7'h7F,
            "R1 strobes inactive in reset", 32'({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, busack_n}), 32'h7F);
        chk({addr_oe, ctrl_oe, data_oe} == 3'b000, "R1 buses floated in reset",
            32'({addr_oe, ctrl_oe, data_oe}), 32'd0);
        chk(pc_value == 16'd0 && r_value == 8'd0, "R1 pc and refresh cleared",
            32'({pc_value, r_value}), 32'd0);
        rst = 1'b0;
        pc_m = '0; r_m = '0; i_m = '0;
        @(negedge clk);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                chk(1'b0, "watchdog expired", 32'(cycles), 32'd100000);
                report();
            end
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        i_load = 1'b1; i_val = 8'hA5;
        @(negedge clk);
        i_load = 1'b0; i_m = 8'hA5;

        for (int k = 0; k < 6; k++) begin
            for (int w = 0; w < 3; w++) begin
                run_cyc(k, 16'h1000 + 16'(k * 16 + w), 8'h3C ^ 8'(k * 7 + w), w, 8'h5A + 8'(k * 3 + w));
            end
        end

        // R4/R5: wrap of the low seven bits, bit 7 kept
        load_r(8'h7E);
        run_cyc(0, 16'h0, 8'h0, 0, 8'h11);
        run_cyc(0, 16'h0, 8'h0, 0, 8'h12);
        chk(r_value == 8'h00, "R4 wrap with bit 7 clear", 32'(r_value), 32'h00);
        load_r(8'hFE);
        run_cyc(5, 16'h0, 8'h0, 0, 8'h13);
        run_cyc(0, 16'h0, 8'h0, 1, 8'h14);
        chk(r_value == 8'h80, "R4 wrap keeps bit 7 set", 32'(r_value), 32'h80);

        // R4: long sweep of fetches through more than one full wrap
        for (int j = 0; j < 130; j++) begin
            run_cyc(0, 16'h0, 8'h0, j % 3, 8'(j));
        end

        // R11: bus request while idle, with a pending cycle request
        busreq_n = 1'b0; req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h4321;
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            chk(busack_n == 1'b0, "R11 grant given", 32'(busack_n), 32'd0);
            chk({addr_oe, ctrl_oe, data_oe} == 3'b000, "R11 buses floated",
                32'({addr_oe, ctrl_oe, data_oe}), 32'd0);
            chk(done == 1'b0, "R11 no cycle during grant", 32'(done), 32'd0);
            @(negedge clk);
        end
        busreq_n = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        chk(busack_n == 1'b1 && addr_oe == 1'b1 && ready == 1'b1, "R11 grant released",
            32'({busack_n, addr_oe, ready}), 32'h7);
        chk(pc_value == pc_m && r_value == r_m, "R11 no cycle ran", 32'({pc_value, r_value}), 32'({pc_m, r_m}));

        // R11: request raised in T2 waits for the fetch to end
        busreq_at = 2;
        run_cyc(0, 16'h0, 8'h0, 1, 8'h77);
        busreq_at = 0;
        @(negedge clk);
        chk(busack_n == 1'b0 && addr_oe == 1'b0, "R11 grant after cycle end",
            32'({busack_n, addr_oe}), 32'd0);
        busreq_n = 1'b1;
        @(negedge clk);

        // R1: reset clears loaded state; refresh page then reads zero
        load_r(8'hC3);
        do_reset();
        run_cyc(0, 16'h0, 8'h0, 0, 8'h99);

        report();
    end

endmodule